// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block raises a CPU interrupt once a programmed number of video scanlines has passed. It has no timing source of its own. It watches video address line A12, and each scanline produces one rising edge on that line once the picture fetch changes pattern table. An edge counts only if A12 has been low for long enough first, so short glitches on the line do not advance the count. Each counted edge drives an 8-bit down counter. The counter reloads from a software-written latch when it is zero or when software has asked for a reload, and otherwise it decrements by one.

The CPU controls the block through four write-only registers in two address windows. The counter window holds the latch value at even addresses and the reload request at odd addresses. The interrupt window holds interrupt disable and acknowledge at even addresses and interrupt enable at odd addresses. A pending interrupt holds the active-low request line low until software writes the disable register.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset the counter, latch, reload request, enable and pending flags are all zero and `irq_n` is high. Edges counted after reset raise no interrupt until a nonzero latch value is loaded.
- R2: A rising A12 counts as a scanline clock only when A12 was sampled low on at least MIN_LOW (default 3) consecutive CPU clock edges just before the edge that samples it high. Lows that last fewer samples are ignored.
- R3: On each scanline clock the counter takes the latch value if it is zero or a reload is requested, and the reload request is cleared. In every other case the counter decreases by one.
- R4: A scanline clock that moves the counter from a nonzero value to zero sets the pending flag if interrupts are enabled. `irq_n` is low exactly while the pending flag is set.
- R5: A write with `win_counter` high and `cpu_a0` = 0 stores `cpu_data` in the latch and leaves the running count unchanged.
- R6: A write with `win_counter` high and `cpu_a0` = 1 requests a reload for the next scanline clock. A request written in the same cycle as a scanline clock survives that clock, which decrements normally, and is used by the following one.
- R7: A write with `win_irqctl` high and `cpu_a0` = 0 clears both enable and pending. A write with `win_irqctl` high and `cpu_a0` = 1 sets enable. Neither write changes the count.
- R8: The counter keeps decrementing and reloading while interrupts are disabled.
- R9: With latch value N (1 to 255) and a reload requested, the interrupt arrives on scanline N+1. It then recurs every N+1 scanlines after each acknowledge.
- R10: If zero is loaded into the latch and a reload is requested while the count is nonzero, exactly one interrupt follows on the next scanline clock. No further interrupt occurs while the latch stays zero.
- R11: In a cycle where a scanline clock reaches zero and a disable write also occurs, the disable wins and nothing stays pending. An enable write in that same cycle does not yet allow the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_a0 | input | 1 | CPU address bit 0; picks even or odd register |
| win_counter | input | 1 | Address decode for the counter register window |
| win_irqctl | input | 1 | Address decode for the interrupt control window |
| cpu_data | input | DATA_W | CPU write data |
| vid_a12 | input | 1 | Video address line A12 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The risky cases are CPU writes that land in the same clock cycle as a counted scanline, because the register update and the counter step then act on the same edge. The bench forces these cases directly. It drives A12 low for the minimum time, raises it, and issues the write exactly one cycle later, which is the cycle the counter consumes the edge. Three writes are placed this way: a reload request, an interrupt disable, and an interrupt enable. Each is judged by the number of scanlines to the next interrupt, or by `irq_n` staying high. A random phase then mixes writes and A12 toggles freely, and a bench model built from the requirements checks `irq_n` after every cycle.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

   // One-cycle register commands decoded from a CPU write
   typedef struct packed {
      logic latch_wr;   // counter window, even address
      logic reload_wr;  // counter window, odd address
      logic irq_off_wr; // interrupt window, even address
      logic irq_on_wr;  // interrupt window, odd address
   } irq_cmd_t;

endpackage

// File: rtl/a12_edge_qualifier.sv
module a12_edge_qualifier #(
   parameter int MIN_LOW     = 3,
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic a12_in,
   output logic line_tick
);
   localparam int LW = $clog2(MIN_LOW + 1);
   localparam logic [LW-1:0] ARM_VAL = LW'(MIN_LOW);

   logic          a12_s;
   logic [LW-1:0] low_cnt;
   logic          armed;

   if (MIN_LOW < 1) begin : g_bad_min
      $error("MIN_LOW must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign a12_s = a12_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], a12_in};
      end
      assign a12_s = chain[SYNC_STAGES-1];
   end

   assign armed = (low_cnt == ARM_VAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt   <= '0;
         line_tick <= 1'b0;
      end else begin
         line_tick <= a12_s && armed;
         if (a12_s)       low_cnt <= '0;
         else if (!armed) low_cnt <= low_cnt + 1'b1;
      end
   end

   // R2: one qualified edge never produces back-to-back clocks
   a_r2_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick |=> !line_tick);

endmodule

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
   import scanline_irq_pkg::*;
(
   input  logic     cpu_wr,
   input  logic     cpu_a0,
   input  logic     win_counter,
   input  logic     win_irqctl,
   output irq_cmd_t cmd
);
   always_comb begin
      cmd.latch_wr   = cpu_wr && win_counter && !cpu_a0;
      cmd.reload_wr  = cpu_wr && win_counter &&  cpu_a0;
      cmd.irq_off_wr = cpu_wr && win_irqctl  && !cpu_a0;
      cmd.irq_on_wr  = cpu_wr && win_irqctl  &&  cpu_a0;
   end
endmodule

// File: rtl/line_down_counter.sv
module line_down_counter
   import scanline_irq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  irq_cmd_t          cmd,
   input  logic [DATA_W-1:0] wdata,
   output logic              pending
);
   logic [CNT_W-1:0] count, latch, next_val;
   logic             reload_flag, enable, hit_zero;

   assign next_val = ((count == '0) || reload_flag) ? latch : count - 1'b1;
   assign hit_zero = line_tick && (count != '0) && (next_val == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count       <= '0;
         latch       <= '0;
         reload_flag <= 1'b0;
         enable      <= 1'b0;
         pending     <= 1'b0;
      end else begin
         if (line_tick)    count <= next_val;
         if (cmd.latch_wr) latch <= wdata[CNT_W-1:0];

         if (cmd.reload_wr)      reload_flag <= 1'b1;
         else if (line_tick)     reload_flag <= 1'b0;

         if (cmd.irq_off_wr)     enable <= 1'b0;
         else if (cmd.irq_on_wr) enable <= 1'b1;

         if (cmd.irq_off_wr)            pending <= 1'b0;
         else if (hit_zero && enable)   pending <= 1'b1;
      end
   end

   // R3: the count moves only on a scanline clock
   a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !line_tick |=> $stable(count));
   // R3: a requested reload copies the latch
   a_r3_reload_takes_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && reload_flag) |=> (count == $past(latch)));
   // R6: a scanline clock consumes the request unless a new one arrives
   a_r6_flag_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && !cmd.reload_wr) |=> !reload_flag);
   // R4: pending rises only after an enabled scanline clock
   a_r4_pending_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> ($past(line_tick) && $past(enable)));
   // R7: disable clears both flags
   a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.irq_off_wr |=> (!pending && !enable));
   // R7: enable write takes effect
   a_r7_on_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.irq_on_wr && !cmd.irq_off_wr) |=> enable);

endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
   import scanline_irq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 8,
   parameter int MIN_LOW     = 3,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_a0,
   input  logic              win_counter,
   input  logic              win_irqctl,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              vid_a12,
   output logic              irq_n
);
   if (CNT_W > DATA_W || CNT_W < 1) begin : g_bad_width
      $error("CNT_W must be between 1 and DATA_W");
   end

   logic     line_tick;
   logic     pending;
   irq_cmd_t cmd;

   a12_edge_qualifier #(
      .MIN_LOW     (MIN_LOW),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .a12_in    (vid_a12),
      .line_tick (line_tick)
   );

   irq_cmd_decode u_dec (
      .cpu_wr      (cpu_wr),
      .cpu_a0      (cpu_a0),
      .win_counter (win_counter),
      .win_irqctl  (win_irqctl),
      .cmd         (cmd)
   );

   line_down_counter #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_tick (line_tick),
      .cmd       (cmd),
      .wdata     (cpu_data),
      .pending   (pending)
   );

   assign irq_n = ~pending;

   // R4: acknowledge through the control window releases the line next cycle
   a_r4_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && win_irqctl && !cpu_a0) |=> irq_n);

endmodule

// File: tb/tb_scanline_irq_counter.sv
`timescale 1ns/1ps
module tb_scanline_irq_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr = 1'b0, cpu_a0 = 1'b0, win_counter = 1'b0, win_irqctl = 1'b0;
   logic [7:0] cpu_data = '0;
   logic       vid_a12 = 1'b0;
   logic       irq_n;

   always #2.5 clk = ~clk;

   scanline_irq_counter dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_a0(cpu_a0),
      .win_counter(win_counter), .win_irqctl(win_irqctl),
      .cpu_data(cpu_data), .vid_a12(vid_a12), .irq_n(irq_n));

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   // bench model state, built from the requirements
   int         m_low = 0;
   bit         m_tick = 0, m_rel = 0, m_en = 0, m_pend = 0;
   logic [7:0] m_cnt = 0, m_latch = 0;
   bit         cur_a12 = 1'b0;

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_edge(bit wr, bit a0, bit wc, bit we, logic [7:0] d, bit a12);
      bit nt, hz;
      logic [7:0] nv;
      nt = a12 && (m_low >= 3);
      nv = (m_cnt == 0 || m_rel) ? m_latch : m_cnt - 8'd1;
      hz = m_tick && (m_cnt != 0) && (nv == 0);
      if (wr && we && !a0)   m_pend = 0;
      else if (hz && m_en)   m_pend = 1;
      if (wr && we && !a0)   m_en = 0;
      else if (wr && we && a0) m_en = 1;
      if (wr && wc && a0)    m_rel = 1;
      else if (m_tick)       m_rel = 0;
      if (m_tick)            m_cnt = nv;
      if (wr && wc && !a0)   m_latch = d;
      m_low  = a12 ? 0 : ((m_low < 3) ? m_low + 1 : 3);
      m_tick = nt;
   endtask

   task automatic step(bit wr, bit a0, bit wc, bit we, logic [7:0] d, bit a12, string req);
      @(negedge clk);
      cpu_wr = wr; cpu_a0 = a0; win_counter = wc; win_irqctl = we;
      cpu_data = d; vid_a12 = a12; cur_a12 = a12;
      model_edge(wr, a0, wc, we, d, a12);
      @(posedge clk);
      #1;
      check(irq_n == !m_pend, req, irq_n, !m_pend);
   endtask

   task automatic wreg(bit irqwin, bit a0, logic [7:0] d, string req);
      step(1'b1, a0, !irqwin, irqwin, d, cur_a12, req);
      step(1'b0, 1'b0, 1'b0, 1'b0, 8'd0, cur_a12, req);
   endtask

   task automatic line(int lowlen, string req);
      for (int i = 0; i < lowlen; i++) step(0, 0, 0, 0, 8'd0, 1'b0, req);
      for (int i = 0; i < 3; i++)      step(0, 0, 0, 0, 8'd0, 1'b1, req);
   endtask

   task automatic lines_to_irq(int maxl, int lowlen, string req, output int n);
      n = 0;
      for (int i = 1; i <= maxl; i++) begin
         line(lowlen, req);
         if (irq_n == 1'b0) begin n = i; return; end
      end
   endtask

   task automatic ack(string req);
      wreg(1, 0, 8'd0, req);
      wreg(1, 1, 8'd0, req);
   endtask

   // low for the minimum time, high edge, then a write in the consuming cycle
   task automatic edge_with_write(bit irqwin, bit a0, logic [7:0] d, string req);
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 8'd0, 1'b0, req);
      step(0, 0, 0, 0, 8'd0, 1'b1, req);
      step(1, a0, !irqwin, irqwin, d, 1'b1, req);
      step(0, 0, 0, 0, 8'd0, 1'b1, req);
      step(0, 0, 0, 0, 8'd0, 1'b1, req);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(irq_n == 1'b1, "R1", irq_n, 1);

      // R1: all-zero state gives no interrupt even when enabled
      wreg(1, 1, 8'd0, "R1");
      for (int i = 0; i < 4; i++) line(4, "R1");
      check(irq_n == 1'b1, "R1", irq_n, 1);

      // R9: period N+1, twice
      wreg(0, 0, 8'd3, "R9");
      wreg(0, 1, 8'd0, "R9");
      lines_to_irq(10, 4, "R9", n);
      check(n == 4, "R9", n, 4);
      ack("R9");
      lines_to_irq(10, 4, "R9", n);
      check(n == 4, "R9", n, 4);
      ack("R4");
      check(irq_n == 1'b1, "R4", irq_n, 1);

      // R2: short lows are ignored
      wreg(0, 0, 8'd2, "R2");
      wreg(0, 1, 8'd0, "R2");
      for (int i = 0; i < 6; i++) line(2, "R2");
      check(irq_n == 1'b1, "R2", irq_n, 1);
      lines_to_irq(10, 3, "R2", n);
      check(n == 3, "R2", n, 3);
      ack("R2");

      // R8: counting continues while disabled
      wreg(0, 0, 8'd5, "R8");
      wreg(0, 1, 8'd0, "R8");
      for (int i = 0; i < 3; i++) line(4, "R8");
      wreg(1, 0, 8'd0, "R8");
      for (int i = 0; i < 3; i++) line(4, "R8");
      check(irq_n == 1'b1, "R8", irq_n, 1);
      wreg(1, 1, 8'd0, "R7");
      lines_to_irq(10, 4, "R8", n);
      check(n == 6, "R8", n, 6);
      ack("R7");

      // R10: zero latch gives a single interrupt
      wreg(0, 0, 8'd2, "R10");
      wreg(0, 1, 8'd0, "R10");
      line(4, "R10");
      wreg(0, 0, 8'd0, "R10");
      wreg(0, 1, 8'd0, "R10");
      line(4, "R10");
      check(irq_n == 1'b0, "R10", irq_n, 0);
      ack("R10");
      for (int i = 0; i < 5; i++) line(4, "R10");
      check(irq_n == 1'b1, "R10", irq_n, 1);

      // R5: latch write does not touch the running count
      wreg(0, 0, 8'd3, "R5");
      wreg(0, 1, 8'd0, "R5");
      line(4, "R5");
      wreg(0, 0, 8'd9, "R5");
      lines_to_irq(12, 4, "R5", n);
      check(n == 3, "R5", n, 3);
      ack("R5");

      // R6: reload request in the cycle of a scanline clock
      wreg(0, 0, 8'd2, "R6");
      wreg(0, 1, 8'd0, "R6");
      line(4, "R6");
      wreg(0, 0, 8'd5, "R6");
      edge_with_write(0, 1, 8'd0, "R6");
      check(irq_n == 1'b1, "R6", irq_n, 1);
      lines_to_irq(10, 4, "R6", n);
      check(n == 6, "R6", n, 6);
      ack("R6");

      // R11: disable coincident with reaching zero
      wreg(0, 0, 8'd1, "R11");
      wreg(0, 1, 8'd0, "R11");
      line(4, "R11");
      edge_with_write(1, 0, 8'd0, "R11");
      check(irq_n == 1'b1, "R11", irq_n, 1);
      // R11: enable coincident with reaching zero
      wreg(0, 1, 8'd0, "R11");
      line(4, "R11");
      edge_with_write(1, 1, 8'd0, "R11");
      check(irq_n == 1'b1, "R11", irq_n, 1);
      ack("R11");

      // R3 R4 R7: random mix checked against the model every cycle
      for (int k = 0; k < 600; k++) begin
         bit a12v;
         int hold;
         a12v = $urandom % 2;
         hold = 1 + ($urandom % 6);
         for (int j = 0; j < hold; j++) begin
            if (($urandom % 8) == 0) begin
               bit w;
               w = $urandom % 2;
               step(1, $urandom % 2, !w, w, 8'($urandom % 8), a12v, "R3 R4 R7");
            end else begin
               step(0, 0, 0, 0, 8'd0, a12v, "R3 R4 R7");
            end
         end
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule